// File: doc/BRIEF.md
# Clock-Configuration Serial Register Loader

This block is a write-only two-wire (I2C) target that fills a small bank of configuration registers for a clock generator. The registers select the output frequency, turn spread-spectrum modulation on or off and gate individual clock outputs. The block samples SCL and SDA with its own system clock. It finds start and stop conditions, compares the address byte with its own address and pulls SDA low in the acknowledge slot of every byte it accepts.

A host writes a fixed frame: the address byte, a command byte, a count byte and then the data bytes. The command byte and the count byte are acknowledged but have no effect. Data always lands in register 0 first and then in each following register. Register 0 carries the frequency-select and spread-enable bits, and register 4 carries one enable bit per output.

The controller `cfgi2c_fsm` has the states ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_CNT, ST_CNT_ACK, ST_DATA, ST_DATA_ACK and ST_IGNORE. A start condition moves any state to ST_ADDR, and a stop condition moves any state to ST_IDLE. The other transitions take place on a falling SCL edge:
- ST_ADDR goes to ST_ADDR_ACK after eight bits if the byte matches, and to ST_IGNORE if it does not.
- ST_ADDR_ACK goes to ST_CMD.
- ST_CMD goes to ST_CMD_ACK after eight bits, and ST_CMD_ACK goes to ST_CNT.
- ST_CNT goes to ST_CNT_ACK after eight bits, and ST_CNT_ACK goes to ST_DATA.
- ST_DATA goes to ST_DATA_ACK after eight bits and stores the byte. ST_DATA_ACK returns to ST_DATA.
- ST_IDLE and ST_IGNORE stay where they are until a start or stop condition arrives.

Top module: `cfg_i2c_slave`

## Requirements
- R1: On reset, register 0 holds 0x00, registers 1 to 5 hold 0xFF and sda_oe is low.
- R2: The address byte 0xD2 (7-bit address 0x69, write direction) is acknowledged. The acknowledge is sda_oe high during the ninth SCL clock of the byte.
- R3: Any other address byte is not acknowledged, and neither is any later byte up to the next start. The registers stay unchanged.
- R4: The two bytes after a matching address are acknowledged and discarded, whatever their values.
- R5: Later bytes are received MSB first, acknowledged and stored in registers 0, 1, 2, 3, 4 and 5 in that order. Register n appears on cfg_bank[8n+7:8n].
- R6: Data bytes after the sixth are acknowledged but leave every register unchanged.
- R7: A start condition, including a repeated start in the middle of a transfer, restarts at the address phase, and the next data byte goes to register 0.
- R8: After a stop condition, bytes clocked without a new start are not acknowledged and have no effect.
- R9: spread_en is bit 3 of register 0. out_en is register 4, where a 1 enables the matching output.
- R10: sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_bank | output | NUM_REGS*8 | Register contents, register n at bits 8n+7:8n |
| spread_en | output | 1 | Spread-spectrum enable from register 0 |
| out_en | output | 8 | Per-output enables from register 4 |

## Verification
The assertions assume that the host obeys the bus rules. SDA changes only while SCL is low, except to make a start or stop condition. No start or stop condition falls in an acknowledge slot. Each SCL level lasts longer than the synchronizer delay. The bench drives SCL with a fixed period of several system clocks and changes SDA only in the middle of the low phase. It models SDA as a wired-AND of the host and the block, so the block's acknowledge holds the line low and no edge can appear on SDA during that slot.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
    localparam int BYTE_W = 8;
    localparam int BITCNT_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_t;
endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '1;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfgi2c_cond.sv
module cfgi2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
    end
endmodule

// File: rtl/cfgi2c_fsm.sv
module cfgi2c_fsm
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 6,
    localparam int        IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output bus_state_t        state
);
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
    localparam logic [IDX_W-1:0]  IDX_END   = IDX_W'(NUM_REGS);

    bus_state_t              state_nx;
    logic [BYTE_W-1:0]       shift_q;
    logic [BITCNT_W-1:0]     bit_cnt;
    logic [IDX_W-1:0]        idx_q;
    logic                    byte_phase;
    logic                    ack_phase;
    logic                    byte_done;

    always_comb begin
        byte_phase = (state == ST_ADDR) || (state == ST_CMD) ||
                     (state == ST_CNT)  || (state == ST_DATA);
        ack_phase  = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                     (state == ST_CNT_ACK)  || (state == ST_DATA_ACK);
        byte_done  = scl_fall && (bit_cnt == BITCNT_W'(BYTE_W));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) state_nx = (shift_q == ADDR_BYTE) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_nx = ST_CMD;
                ST_CMD:      if (byte_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall)  state_nx = ST_CNT;
                ST_CNT:      if (byte_done) state_nx = ST_CNT_ACK;
                ST_CNT_ACK:  if (scl_fall)  state_nx = ST_DATA;
                ST_DATA:     if (byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_nx = ST_DATA;
                ST_IGNORE:   state_nx = ST_IGNORE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // bit shifter, bit counter and register index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_cnt <= '0;
            idx_q   <= '0;
        end else if (start_det) begin
            bit_cnt <= '0;
            idx_q   <= '0;
        end else begin
            if (scl_rise && byte_phase && (bit_cnt != BITCNT_W'(BYTE_W))) begin
                shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall && ack_phase) begin
                bit_cnt <= '0;
            end
            if (wr_en) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = ack_phase;
        wr_en   = (state == ST_DATA) && byte_done && (idx_q != IDX_END) && !start_det && !stop_det;
        wr_idx  = idx_q;
        wr_data = shift_q;
    end
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
    import cfgi2c_pkg::*;
#(
    parameter int                         NUM_REGS  = 6,
    parameter logic [NUM_REGS*BYTE_W-1:0] RESET_VAL = {{(NUM_REGS-1){8'hFF}}, 8'h00},
    localparam int                        IDX_W     = $clog2(NUM_REGS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [NUM_REGS*BYTE_W-1:0]   bank
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[r*BYTE_W +: BYTE_W] <= RESET_VAL[r*BYTE_W +: BYTE_W];
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                bank[r*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 6,
    parameter int         SYNC_STAGES = 2,
    parameter int         SPREAD_BIT  = 3,
    parameter int         OUTEN_REG   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_bank,
    output logic                       spread_en,
    output logic [BYTE_W-1:0]          out_en
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);

    logic [1:0]        line_s;
    logic              scl_s;
    logic              sda_s;
    logic              start_det;
    logic              stop_det;
    logic              scl_rise;
    logic              scl_fall;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    bus_state_t        state;

    cfgi2c_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    cfgi2c_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    cfgi2c_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .state    (state)
    );

    cfgi2c_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .bank   (cfg_bank)
    );

    assign spread_en = cfg_bank[SPREAD_BIT];
    assign out_en    = cfg_bank[OUTEN_REG*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
    import cfgi2c_pkg::*;
#(
    parameter int  NUM_REGS = 6,
    localparam int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_s,
    input logic                       start_det,
    input logic                       stop_det,
    input bus_state_t                 state,
    input logic                       sda_oe,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_bank
);
    // R10: acknowledge drive is applied only while SCL is low
    a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R10: acknowledge drive is released only while SCL is low
    a_r10_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);

    // R6: no write reaches beyond the last register
    a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

    // R7: a start condition always lands in the address phase
    a_r7_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R8: a stop condition returns to idle with the line released
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

    // R3: registers change only through a write strobe
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_bank));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .state    (state),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .cfg_bank (cfg_bank)
);

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;
    localparam int Q = 4;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [47:0] cfg_bank;
    logic        spread_en;
    logic [7:0]  out_en;

    logic [47:0] exp_bank;
    logic [7:0]  tx [0:9];
    int          n_checks = 0;
    int          n_errors = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    cfg_i2c_slave u_cfg_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_bank (cfg_bank),
        .spread_en(spread_en),
        .out_en   (out_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wait_clk(Q);
        scl_h = 1'b1; wait_clk(H);
        sda_h = 1'b0; wait_clk(H);
        scl_h = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_h = 1'b0;
        wait_clk(Q); scl_h = 1'b1;
        wait_clk(H); sda_h = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q); sda_h = b[i];
            wait_clk(Q); scl_h = 1'b1;
            wait_clk(H); scl_h = 1'b0;
        end
        wait_clk(Q); sda_h = 1'b1;
        wait_clk(Q); scl_h = 1'b1;
        wait_clk(Q); acked = !sda_line;
        wait_clk(Q); scl_h = 1'b0;
    endtask

    task automatic check_bank(input string tag);
        wait_clk(6);
        check(cfg_bank == exp_bank, tag, cfg_bank, exp_bank);
        check(spread_en == exp_bank[3], "R9 spread_en", {47'd0, spread_en}, {47'd0, exp_bank[3]});
        check(out_en == exp_bank[39:32], "R9 out_en", {40'd0, out_en}, {40'd0, exp_bank[39:32]});
    endtask

    // frame of address, command, count and n bytes of tx[]; no stop
    task automatic frame(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        check(a, "R2 address ack", {47'd0, a}, 48'd1);
        send_byte(cmd, a);
        check(a, "R4 command ack", {47'd0, a}, 48'd1);
        send_byte(cnt, a);
        check(a, "R4 count ack", {47'd0, a}, 48'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], a);
            check(a, (i < 6) ? "R5 data ack" : "R6 extra data ack", {47'd0, a}, 48'd1);
            if (i < 6) exp_bank[i*8 +: 8] = tx[i];
        end
    endtask

    initial begin
        logic a;
        exp_bank = {{5{8'hFF}}, 8'h00};
        wait_clk(5);
        check(cfg_bank == exp_bank, "R1 reset bank", cfg_bank, exp_bank);
        check(sda_oe == 1'b0, "R1 reset sda_oe", {47'd0, sda_oe}, 48'd0);
        rst_n = 1'b1;
        wait_clk(5);

        // R5 R6 R4: sweep of data-byte counts and command/count values
        for (int k = 0; k <= 8; k++) begin
            for (int i = 0; i < 10; i++) tx[i] = 8'((k * 37 + i * 11 + 5) ^ (i << 4));
            frame(8'((k * 29) ^ 8'hA5), 8'(k * 53), k);
            bus_stop();
            check_bank("R5 bank after write");
        end

        // R9: spread bit set and cleared
        tx[0] = 8'h08; tx[1] = 8'h00; tx[2] = 8'h11; tx[3] = 8'h22; tx[4] = 8'h5A; tx[5] = 8'hC3;
        frame(8'h00, 8'h06, 6); bus_stop(); check_bank("R9 spread set");
        tx[0] = 8'hF7; tx[4] = 8'h00;
        frame(8'hFF, 8'hFF, 6); bus_stop(); check_bank("R9 spread clear");

        // R7: repeated start in mid-transfer restarts at register 0
        tx[0] = 8'h31; tx[1] = 8'h42;
        frame(8'h00, 8'h06, 2);
        tx[0] = 8'h9C;
        frame(8'h00, 8'h06, 1);
        bus_stop();
        check_bank("R7 repeated start");

        // R8: bytes without a start after stop
        send_byte(8'hD2, a);
        check(!a, "R8 no ack without start", {47'd0, a}, 48'd0);
        send_byte(8'h77, a);
        check(!a, "R8 no ack without start", {47'd0, a}, 48'd0);
        check_bank("R8 bank unchanged");

        // R3: every other address byte
        for (int ad = 0; ad < 256; ad++) begin
            if (ad != 8'hD2) begin
                bus_start();
                send_byte(8'(ad), a);
                check(!a, "R3 foreign address nack", {47'd0, a}, 48'd0);
                send_byte(8'(ad ^ 8'h5F), a);
                check(!a, "R3 following byte nack", {47'd0, a}, 48'd0);
                bus_stop();
            end
        end
        check_bank("R3 bank unchanged");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule